// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a small bank of control registers for a workstation I/O companion device. Software reaches it through a simple synchronous register bus. Each register region has its own select line, and every access carries a byte offset, write data, a write or read strobe, and a registered read result. The bank holds these registers:

- a configuration byte;
- a diagnostic byte;
- a modem-control byte;
- a 16-bit LED word;
- two auxiliary bytes;
- a 32-bit system-control word;
- a CPU-idle strobe location.

From these the block derives a power-fail interrupt, a one-cycle floppy terminal-count pulse, a one-cycle power-off request, a one-cycle system-reset request and a sticky CPU-halt level. A power-fail sense line comes from outside the block. The block records that line only while the interrupt is enabled. Software acknowledges the event through the second auxiliary register.

The block does not carry out shutdown, reset, floppy control or CPU halting. It only drives the request outputs. The diagnostic and system-control registers have no reset, so their contents survive a block reset.

Top module: `auxctl_regs`

## Requirements
- R1: After reset the configuration, modem-control, aux-1 and aux-2 registers read 0x00. `pf_irq`, `tc_pulse`, `pwroff_req`, `rst_req`, `cpu_halt` and `rdata` are all low. Select bit indices are: 0 configuration, 1 diagnostic, 2 modem-control, 3 LED, 4 system-control, 5 aux-1, 6 aux-2, 7 CPU-idle.
- R2: The configuration, diagnostic and modem-control registers store all 8 written bits at any offset. A read returns the value zero-extended on `rdata` one cycle after the read strobe. A cycle without a read strobe drives `rdata` to 0.
- R3: A block reset leaves the diagnostic register and the system-control register unchanged.
- R4: Every change of `pf_in` sets aux-2 bit 5 to the new `pf_in` value ANDed with configuration bit 3, and clears it otherwise. A change of `pf_in` takes precedence over an aux-2 write in the same cycle.
- R5: `pf_irq` is high exactly when aux-2 bit 5 and configuration bit 3 are both set. Clearing configuration bit 3 drops `pf_irq` without clearing aux-2 bit 5.
- R6: An aux-2 write stores write-data bit 0 into bit 0 and keeps bit 5 unless write-data bit 1 is set, in which case bit 5 is cleared. Bit 1 and all other bits always read 0.
- R7: An aux-2 write with data bit 0 set drives `pwroff_req` high for exactly the cycle after the write. A write with data bit 0 clear does not drive it.
- R8: An aux-1 write with data bit 1 set drives `tc_pulse` high for exactly the cycle after the write. The register stores the data with bit 1 forced to 0.
- R9: A system-control write at offset 0 with data bit 0 set loads 0x02 and drives `rst_req` high for one cycle. Writes at other offsets, or with bit 0 clear, change nothing. Reads at offset 0 return the value and reads at other offsets return 0.
- R10: The LED word stores 16 bits only on writes at offset 0. It reads back at offset 0. Other offsets read 0 and ignore writes.
- R11: The CPU-idle region always reads 0. Any write to it sets `cpu_halt`, which stays high until block reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| reg_sel | input | 8 | One-hot region select, indices as in R1 |
| addr | input | 2 | Byte offset inside the selected region |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| pf_in | input | 1 | External power-fail sense |
| pf_irq | output | 1 | Power-fail interrupt level |
| tc_pulse | output | 1 | Floppy terminal-count pulse |
| pwroff_req | output | 1 | Power-off request pulse |
| rst_req | output | 1 | System-reset request pulse |
| cpu_halt | output | 1 | Sticky CPU halt level |

## Verification
A wrong aux-2 bit 5 shows at the ports in two ways. `pf_irq` is already wrong in the cycle after the power-fail edge or the write that corrupted the bit. An aux-2 read one cycle later exposes the raw bit even while the enable is clear, because the interrupt is masked but the bit is not. Wrong pulse logic shows on the request outputs in the single cycle after the triggering write: the pulse is missing, lasts two cycles, or appears on a write that should not produce one. A register that stores or clears wrongly shows in the next read, one cycle after the read strobe.

// File: rtl/auxctl_pkg.sv
package auxctl_pkg;
  localparam int NUM_REGIONS = 8;
  localparam int SEL_CFG  = 0;
  localparam int SEL_DIAG = 1;
  localparam int SEL_MDM  = 2;
  localparam int SEL_LED  = 3;
  localparam int SEL_SYS  = 4;
  localparam int SEL_AUX1 = 5;
  localparam int SEL_AUX2 = 6;
  localparam int SEL_IDLE = 7;

  localparam int CFG_PF_EN   = 3;
  localparam int AUX2_OFF    = 0;
  localparam int AUX2_ACK    = 1;
  localparam int AUX2_PF     = 5;
  localparam int AUX1_TC     = 1;
  localparam logic [7:0] SYS_RESET_CODE = 8'h02;

  // aux-2 value after a write: only the off bit comes from data, the
  // latched fail flag survives unless the acknowledge bit is set
  function automatic logic [7:0] aux2_after_write(logic [7:0] d, logic pf_now);
    logic [7:0] r;
    r = '0;
    r[AUX2_OFF] = d[AUX2_OFF];
    r[AUX2_PF]  = pf_now & ~d[AUX2_ACK];
    return r;
  endfunction

  // aux-1 never keeps the terminal-count bit
  function automatic logic [7:0] aux1_after_write(logic [7:0] d);
    logic [7:0] r;
    r = d;
    r[AUX1_TC] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/auxctl_pwr.sv
module auxctl_pwr
  import auxctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_cfg,
  input  logic       wr_aux2,
  input  logic [7:0] wbyte,
  input  logic       pf_in,
  output logic [7:0] cfg_q,
  output logic [7:0] aux2_q,
  output logic       pf_irq,
  output logic       pwroff_req
);
  logic       pf_prev_q;
  logic       pf_chg;
  logic       pf_en;
  logic [7:0] aux2_d;

  assign pf_chg = pf_in ^ pf_prev_q;
  assign pf_en  = cfg_q[CFG_PF_EN];

  always_comb begin
    aux2_d = aux2_q;
    if (wr_aux2) aux2_d = aux2_after_write(wbyte, aux2_q[AUX2_PF]);
    if (pf_chg)  aux2_d[AUX2_PF] = pf_in & pf_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_prev_q  <= 1'b0;
      cfg_q      <= '0;
      aux2_q     <= '0;
      pwroff_req <= 1'b0;
    end else begin
      pf_prev_q  <= pf_in;
      if (wr_cfg) cfg_q <= wbyte;
      aux2_q     <= aux2_d;
      pwroff_req <= wr_aux2 & wbyte[AUX2_OFF];
    end
  end

  assign pf_irq = aux2_q[AUX2_PF] & pf_en;

  // R4
  pf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_chg && pf_in && pf_en && !wr_cfg) |=> pf_irq);
  // R4
  pf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_chg && !pf_in) |=> !pf_irq);
  // R6
  pf_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_aux2 && wbyte[AUX2_ACK] && !pf_chg) |=> !pf_irq);
  // R5
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !wbyte[CFG_PF_EN]) |=> !pf_irq);
  // R7
  pwroff_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwroff_req |-> $past(wr_aux2 && wbyte[AUX2_OFF]));
endmodule

// File: rtl/auxctl_misc.sv
module auxctl_misc
  import auxctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_diag,
  input  logic       wr_mdm,
  input  logic       wr_aux1,
  input  logic [7:0] wbyte,
  output logic [7:0] diag_q,
  output logic [7:0] mdm_q,
  output logic [7:0] aux1_q,
  output logic       tc_pulse
);
  logic tc_fire;
  assign tc_fire = wr_aux1 & wbyte[AUX1_TC];

  // diagnostic byte: no reset on purpose
  always_ff @(posedge clk) begin
    if (wr_diag) diag_q <= wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdm_q    <= '0;
      aux1_q   <= '0;
      tc_pulse <= 1'b0;
    end else begin
      if (wr_mdm)  mdm_q  <= wbyte;
      if (wr_aux1) aux1_q <= aux1_after_write(wbyte);
      tc_pulse <= tc_fire;
    end
  end

  // R8
  tc_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_aux1 && wbyte[AUX1_TC]) |=> tc_pulse);
  // R8
  tc_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_aux1 |=> !aux1_q[AUX1_TC]);
  // R8
  tc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> $past(wr_aux1));
endmodule

// File: rtl/auxctl_sys.sv
module auxctl_sys
  import auxctl_pkg::*;
#(
  parameter int LED_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_led,
  input  logic             wr_sys,
  input  logic             wr_idle,
  input  logic             at_base,
  input  logic [LED_W-1:0] wled,
  input  logic             wsys0,
  output logic [LED_W-1:0] led_q,
  output logic [7:0]       sys_q,
  output logic             rst_req,
  output logic             cpu_halt
);
  logic sys_fire;
  assign sys_fire = wr_sys & at_base & wsys0;

  // LED word and system-control byte have no reset
  always_ff @(posedge clk) begin
    if (wr_led && at_base) led_q <= wled;
    if (sys_fire)          sys_q <= SYS_RESET_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      cpu_halt <= 1'b0;
    end else begin
      rst_req <= sys_fire;
      if (wr_idle) cpu_halt <= 1'b1;
    end
  end

  // R9
  sys_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_fire |=> (rst_req && sys_q == SYS_RESET_CODE));
  // R9
  rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(wr_sys && at_base));
  // R11
  halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_halt) |-> $past(wr_idle));
  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |=> cpu_halt);
endmodule

// File: rtl/auxctl_regs.sv
module auxctl_regs
  import auxctl_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int LED_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_REGIONS-1:0] reg_sel,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   wr_en,
  input  logic                   rd_en,
  output logic [DATA_W-1:0]      rdata,
  input  logic                   pf_in,
  output logic                   pf_irq,
  output logic                   tc_pulse,
  output logic                   pwroff_req,
  output logic                   rst_req,
  output logic                   cpu_halt
);
  localparam int BYTE_PAD = DATA_W - 8;
  localparam int LED_PAD  = DATA_W - LED_W;

  logic [NUM_REGIONS-1:0] wr_hit;
  logic                   at_base;
  logic [7:0]             wbyte;
  logic                   unused_hi;

  assign wr_hit    = reg_sel & {NUM_REGIONS{wr_en}};
  assign at_base   = (addr == '0);
  assign wbyte     = wdata[7:0];
  assign unused_hi = ^wdata[DATA_W-1:LED_W];

  logic [7:0]       cfg_q, aux2_q, diag_q, mdm_q, aux1_q, sys_q;
  logic [LED_W-1:0] led_q;

  auxctl_pwr u_pwr (
    .clk(clk), .rst_n(rst_n),
    .wr_cfg(wr_hit[SEL_CFG]), .wr_aux2(wr_hit[SEL_AUX2]),
    .wbyte(wbyte), .pf_in(pf_in),
    .cfg_q(cfg_q), .aux2_q(aux2_q),
    .pf_irq(pf_irq), .pwroff_req(pwroff_req)
  );

  auxctl_misc u_misc (
    .clk(clk), .rst_n(rst_n),
    .wr_diag(wr_hit[SEL_DIAG]), .wr_mdm(wr_hit[SEL_MDM]),
    .wr_aux1(wr_hit[SEL_AUX1]), .wbyte(wbyte),
    .diag_q(diag_q), .mdm_q(mdm_q), .aux1_q(aux1_q),
    .tc_pulse(tc_pulse)
  );

  auxctl_sys #(.LED_W(LED_W)) u_sys (
    .clk(clk), .rst_n(rst_n),
    .wr_led(wr_hit[SEL_LED]), .wr_sys(wr_hit[SEL_SYS]),
    .wr_idle(wr_hit[SEL_IDLE]), .at_base(at_base),
    .wled(wdata[LED_W-1:0]), .wsys0(wdata[0]),
    .led_q(led_q), .sys_q(sys_q),
    .rst_req(rst_req), .cpu_halt(cpu_halt)
  );

  // read views per region, zero-extended
  logic [DATA_W-1:0] view [NUM_REGIONS];
  always_comb begin
    view[SEL_CFG]  = {{BYTE_PAD{1'b0}}, cfg_q};
    view[SEL_DIAG] = {{BYTE_PAD{1'b0}}, diag_q};
    view[SEL_MDM]  = {{BYTE_PAD{1'b0}}, mdm_q};
    view[SEL_LED]  = at_base ? {{LED_PAD{1'b0}}, led_q} : '0;
    view[SEL_SYS]  = at_base ? {{BYTE_PAD{1'b0}}, sys_q} : '0;
    view[SEL_AUX1] = {{BYTE_PAD{1'b0}}, aux1_q};
    view[SEL_AUX2] = {{BYTE_PAD{1'b0}}, aux2_q};
    view[SEL_IDLE] = '0;
  end

  logic [DATA_W-1:0] rd_term [NUM_REGIONS];
  logic [DATA_W-1:0] rd_mux;
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rd
    assign rd_term[g] = reg_sel[g] ? view[g] : '0;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_REGIONS; i++) rd_mux |= rd_term[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_mux : '0;
  end

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |-> $onehot0(reg_sel));
  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));
  // R11
  idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel[SEL_IDLE]) |=> (rdata == '0));
endmodule

// File: tb/auxctl_regs_tb.sv
module auxctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_sel = '0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic        pf_in = 1'b0;
  logic        pf_irq, tc_pulse, pwroff_req, rst_req, cpu_halt;

  int checks = 0;
  int errors = 0;

  localparam int CFG = 0, DIAG = 1, MDM = 2, LED = 3, SYS = 4,
                 AUX1 = 5, AUX2 = 6, IDLE = 7;

  always #10 clk = ~clk;

  auxctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .addr(addr),
    .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .pf_in(pf_in), .pf_irq(pf_irq), .tc_pulse(tc_pulse),
    .pwroff_req(pwroff_req), .rst_req(rst_req), .cpu_halt(cpu_halt)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int region, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_sel = 8'(1 << region); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    reg_sel = '0; addr = '0; wdata = '0; wr_en = 1'b0;
  endtask

  task automatic rd(int region, logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 8'(1 << region); addr = a; rd_en = 1'b1;
    @(negedge clk);
    reg_sel = '0; addr = '0; rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_pf(logic v);
    @(negedge clk);
    pf_in = v;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    chk("R1 pf_irq", 32'(pf_irq), 0);
    chk("R1 tc", 32'(tc_pulse), 0);
    chk("R1 pwroff", 32'(pwroff_req), 0);
    chk("R1 rst_req", 32'(rst_req), 0);
    chk("R1 halt", 32'(cpu_halt), 0);
    chk("R1 rdata", rdata, 0);
    rd(CFG, 0, v);  chk("R1 cfg", v, 0);
    rd(MDM, 0, v);  chk("R1 mdm", v, 0);
    rd(AUX1, 0, v); chk("R1 aux1", v, 0);
    rd(AUX2, 0, v); chk("R1 aux2", v, 0);
  endtask

  task automatic t_bytes();
    logic [31:0] v;
    wr(DIAG, 2, 32'hFFFF_FF5A);
    wr(MDM, 1, 32'h0000_00C3);
    wr(CFG, 0, 32'h0000_0071);
    rd(DIAG, 0, v); chk("R2 diag", v, 32'h5A);
    rd(MDM, 3, v);  chk("R2 mdm", v, 32'hC3);
    rd(CFG, 0, v);  chk("R2 cfg", v, 32'h71);
    @(negedge clk); chk("R2 rdata idle", rdata, 0);
    wr(CFG, 0, 0);
  endtask

  task automatic t_powerfail();
    logic [31:0] v;
    set_pf(1'b1);
    chk("R4 disabled irq", 32'(pf_irq), 0);
    rd(AUX2, 0, v); chk("R4 disabled bit", v, 0);
    set_pf(1'b0);
    wr(CFG, 0, 32'h08);
    set_pf(1'b1);
    chk("R5 irq on", 32'(pf_irq), 1);
    rd(AUX2, 0, v); chk("R4 bit set", v, 32'h20);
    wr(CFG, 0, 32'h00);
    chk("R5 masked", 32'(pf_irq), 0);
    rd(AUX2, 0, v); chk("R5 bit kept", v, 32'h20);
    wr(CFG, 0, 32'h08);
    chk("R5 unmasked", 32'(pf_irq), 1);
    wr(AUX2, 0, 32'h00);
    chk("R6 kept irq", 32'(pf_irq), 1);
    rd(AUX2, 0, v); chk("R6 kept bit", v, 32'h20);
    wr(AUX2, 0, 32'h02);
    chk("R6 ack irq", 32'(pf_irq), 0);
    rd(AUX2, 0, v); chk("R6 ack value", v, 0);
    set_pf(1'b0);
    set_pf(1'b1);
    chk("R4 re-set", 32'(pf_irq), 1);
    set_pf(1'b0);
    chk("R4 fall clears", 32'(pf_irq), 0);
    rd(AUX2, 0, v); chk("R4 fall bit", v, 0);
  endtask

  task automatic t_pwroff();
    logic [31:0] v;
    wr(AUX2, 0, 32'h01);
    chk("R7 pulse", 32'(pwroff_req), 1);
    @(negedge clk); chk("R7 one cycle", 32'(pwroff_req), 0);
    rd(AUX2, 0, v); chk("R6 off stored", v, 32'h01);
    wr(AUX2, 0, 32'hFC);
    chk("R7 no pulse", 32'(pwroff_req), 0);
    rd(AUX2, 0, v); chk("R6 others ignored", v, 0);
  endtask

  task automatic t_aux1();
    logic [31:0] v;
    wr(AUX1, 0, 32'hFF);
    chk("R8 tc pulse", 32'(tc_pulse), 1);
    @(negedge clk); chk("R8 tc one cycle", 32'(tc_pulse), 0);
    rd(AUX1, 0, v); chk("R8 stored", v, 32'hFD);
    wr(AUX1, 0, 32'h40);
    chk("R8 no tc", 32'(tc_pulse), 0);
    rd(AUX1, 0, v); chk("R8 plain", v, 32'h40);
  endtask

  task automatic t_sys();
    logic [31:0] v;
    wr(SYS, 0, 32'h1);
    chk("R9 rst pulse", 32'(rst_req), 1);
    @(negedge clk); chk("R9 rst one cycle", 32'(rst_req), 0);
    rd(SYS, 0, v); chk("R9 status", v, 32'h2);
    rd(SYS, 1, v); chk("R9 other offset read", v, 0);
    wr(SYS, 2, 32'h1);
    chk("R9 other offset write", 32'(rst_req), 0);
    wr(SYS, 0, 32'hFFFF_FFFE);
    chk("R9 bit0 clear", 32'(rst_req), 0);
    rd(SYS, 0, v); chk("R9 unchanged", v, 32'h2);
  endtask

  task automatic t_led();
    logic [31:0] v;
    wr(LED, 0, 32'h1234_BEEF);
    rd(LED, 0, v); chk("R10 stored", v, 32'hBEEF);
    wr(LED, 2, 32'h0000_1234);
    rd(LED, 0, v); chk("R10 offset write ignored", v, 32'hBEEF);
    rd(LED, 2, v); chk("R10 offset read", v, 0);
  endtask

  task automatic t_idle();
    logic [31:0] v;
    rd(IDLE, 0, v); chk("R11 read zero", v, 0);
    chk("R11 halt low", 32'(cpu_halt), 0);
    wr(IDLE, 0, 32'h0);
    chk("R11 halt set", 32'(cpu_halt), 1);
    repeat (3) @(negedge clk);
    chk("R11 halt held", 32'(cpu_halt), 1);
  endtask

  task automatic t_retention();
    logic [31:0] v;
    wr(DIAG, 0, 32'hA5);
    wr(CFG, 0, 32'h0F);
    wr(MDM, 0, 32'h3C);
    do_reset();
    rd(DIAG, 0, v); chk("R3 diag kept", v, 32'hA5);
    rd(SYS, 0, v);  chk("R3 sys kept", v, 32'h2);
    rd(CFG, 0, v);  chk("R1 cfg cleared", v, 0);
    rd(MDM, 0, v);  chk("R1 mdm cleared", v, 0);
    chk("R11 halt cleared", 32'(cpu_halt), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_bytes();
    t_powerfail();
    t_pwroff();
    t_aux1();
    t_sys();
    t_led();
    t_idle();
    t_retention();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule